// File: doc/BRIEF.md
# Lock-Gated Video Input Start Controller

This block takes a raw clocked video stream (pixel word, data-enable, horizontal sync, vertical sync) and turns it into a gated pixel stream. It measures the incoming format on every frame, whether or not it is enabled. It counts the total lines as horizontal sync leading edges between vertical sync leading edges, and it counts the active lines as lines in which data-enable was seen. When the automatic polarity option is on, it decides for each sync whether that sync is active-low and inverts it if so.

Pixels are forwarded only after software has enabled the block. If software has programmed reference values, the measured format must also have matched those values for a programmed number of consecutive frames. If all reference fields are zero, matching is skipped. Output starts and stops only on a vertical sync leading edge, so frames are never cut. When the horizontal sync stops for a long time, the block flags the input as lost. If the cleaner option is on, it then emits a constant padding pixel built from per-plane values.

Software reaches the block through a small word-addressed register port. Writes take effect on the next clock, and reads are combinational.

Top module: `vid_lock_gate`

## Requirements
- R1: After reset the block transmits nothing: out_valid and out_sof are 0, and the control word (0) and the status word (1) both read 0.
- R2: While disabled, the block still measures every completed frame. Word 7 reads the active line count and word 8 reads the total line count of the most recent completed frame. Total lines are the horizontal sync leading edges from one vertical sync leading edge up to the next, and an edge in the same cycle as the vertical edge belongs to the new frame. Active lines are the lines with at least one data-enable cycle.
- R3: While transmitting, each input cycle with data-enable high produces, one cycle later, out_valid=1 with out_data equal to the input pixel. out_sof is 1 only on the first such pixel of a frame.
- R4: Control word bit 0 enables the block. When every reference field is zero, transmission begins at the first vertical sync leading edge after the enable is set.
- R5: The reference fields are: word 2 bits [11:0] expected total lines, word 2 bits [27:16] expected active lines, word 3 bits [7:0] required frame count (0 counts as 1), and word 3 bits [27:16] expected output (active) lines. A completed frame matches when all three line fields agree with its measurement. Lock holds once the required number of consecutive completed frames have matched.
- R6: A completed frame that does not match resets the consecutive-match count to zero. Transmission stops from the following frame boundary and resumes only after the required number of new matching frames.
- R7: The transmitting state changes only on a vertical sync leading edge. Clearing bit 0 mid-frame lets the current frame finish, and the next frame is not sent. Setting bit 0 mid-frame sends nothing until the next frame.
- R8: A control write that lands in the same cycle as a vertical sync leading edge does not affect the decision made at that edge. It is applied at the following edge.
- R9: Status word bit 4 reads 1 while the block is transmitting and 0 otherwise.
- R10: With control bit 4 set, a sync whose high time exceeds its low time over one period is treated as active-low and inverted. Active-low syncs then give the same measurements and output as active-high ones.
- R11: When no horizontal sync leading edge has been seen for LOSS_LIMIT cycles, input_lost goes to 1 and status bit 1 reads 1. The next horizontal sync leading edge clears both.
- R12: While the input is lost, the block is transmitting and control bit 3 is set, out_valid is 1 on every cycle. out_data is then {word 6, word 5, word 4}, with plane 0 (word 4) in the low PLANE_W bits. With bit 3 clear, a lost input produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_data | input | DATA_W | Input pixel word, PLANES planes of PLANE_W bits |
| vid_de | input | 1 | Input data-enable |
| vid_hs | input | 1 | Input horizontal sync, either polarity |
| vid_vs | input | 1 | Input vertical sync, either polarity |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | DATA_W | Output pixel word |
| out_sof | output | 1 | First output pixel of a frame |
| input_lost | output | 1 | Horizontal sync absent for LOSS_LIMIT cycles |

## Verification
The frame-boundary decision and a software write to the control word can fall in the same clock cycle. The bench provokes this by starting a control write and a frame's first line on the same falling edge, so that both are sampled on the edge that carries the vertical sync leading edge. This is done once to clear the enable and once to set it. The scoreboard then judges that the frame starting at that edge follows the old enable value and that the next frame follows the new one. Lock counting and the boundary decision likewise meet on the same edge, and this is judged by which whole frames reach the output queue.

// File: rtl/vlg_pkg.sv
package vlg_pkg;
    localparam int REG_W     = 32;

    // word addresses
    localparam int A_CTRL    = 0;
    localparam int A_STAT    = 1;
    localparam int A_REFA    = 2;
    localparam int A_REFB    = 3;
    localparam int A_PAD0    = 4;
    localparam int A_MACT    = 7;
    localparam int A_MTOT    = 8;

    // control bits
    localparam int CB_EN     = 0;
    localparam int CB_CLEAN  = 3;
    localparam int CB_APOL   = 4;

    // status bits
    localparam int SB_LOST   = 1;
    localparam int SB_TX     = 4;

    // upper field offset inside reference words
    localparam int HI_FIELD  = 16;
endpackage

// File: rtl/vlg_sync_pol.sv
module vlg_sync_pol #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic raw_in,
    output logic sync_out
);
    typedef struct packed {
        logic             prev;
        logic             inv;
        logic [CNT_W-1:0] hi_run;
        logic [CNT_W-1:0] hi_last;
        logic [CNT_W-1:0] lo_run;
    } pol_t;

    pol_t pol_d, pol_q;
    logic rise, fall;

    always_comb begin
        pol_d      = pol_q;
        pol_d.prev = raw_in;
        rise       = raw_in & ~pol_q.prev;
        fall       = ~raw_in & pol_q.prev;
        if (rise) begin
            // full period seen: judge which phase dominates
            pol_d.inv    = (pol_q.hi_last > pol_q.lo_run);
            pol_d.lo_run = '0;
            pol_d.hi_run = CNT_W'(1);
        end else if (fall) begin
            pol_d.hi_last = pol_q.hi_run;
            pol_d.hi_run  = '0;
            pol_d.lo_run  = CNT_W'(1);
        end else if (raw_in) begin
            if (pol_q.hi_run != '1) pol_d.hi_run = pol_q.hi_run + CNT_W'(1);
        end else begin
            if (pol_q.lo_run != '1) pol_d.lo_run = pol_q.lo_run + CNT_W'(1);
        end
        if (!auto_en) pol_d.inv = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

    assign sync_out = raw_in ^ pol_q.inv;
endmodule

// File: rtl/vlg_measure.sv
module vlg_measure #(
    parameter int LINE_W     = 12,
    parameter int LOSS_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs,
    input  logic              vs,
    input  logic              de,
    output logic              hs_edge,
    output logic              vs_edge,
    output logic              frame_close,
    output logic [LINE_W-1:0] close_act,
    output logic [LINE_W-1:0] close_tot,
    output logic [LINE_W-1:0] meas_act,
    output logic [LINE_W-1:0] meas_tot,
    output logic              lost
);
    localparam int IDLE_W = $clog2(LOSS_LIMIT + 1);

    typedef struct packed {
        logic              hs_p;
        logic              vs_p;
        logic              primed;
        logic              de_seen;
        logic [LINE_W-1:0] line_cnt;
        logic [LINE_W-1:0] act_cnt;
        logic [LINE_W-1:0] m_act;
        logic [LINE_W-1:0] m_tot;
        logic [IDLE_W-1:0] idle;
    } meas_t;

    meas_t m_d, m_q;

    always_comb begin
        hs_edge     = hs & ~m_q.hs_p;
        vs_edge     = vs & ~m_q.vs_p;
        close_act   = m_q.act_cnt + LINE_W'(m_q.de_seen);
        close_tot   = m_q.line_cnt;
        frame_close = vs_edge & m_q.primed;

        m_d      = m_q;
        m_d.hs_p = hs;
        m_d.vs_p = vs;
        if (vs_edge) begin
            m_d.primed   = 1'b1;
            m_d.line_cnt = hs_edge ? LINE_W'(1) : '0;
            m_d.act_cnt  = '0;
            m_d.de_seen  = de;
            if (m_q.primed) begin
                m_d.m_act = close_act;
                m_d.m_tot = close_tot;
            end
        end else if (hs_edge) begin
            if (m_q.line_cnt != '1) m_d.line_cnt = m_q.line_cnt + LINE_W'(1);
            m_d.act_cnt = m_q.act_cnt + LINE_W'(m_q.de_seen);
            m_d.de_seen = de;
        end else begin
            m_d.de_seen = m_q.de_seen | de;
        end

        if (hs_edge)                               m_d.idle = '0;
        else if (m_q.idle != IDLE_W'(LOSS_LIMIT))  m_d.idle = m_q.idle + IDLE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign meas_act = m_q.m_act;
    assign meas_tot = m_q.m_tot;
    assign lost     = (m_q.idle == IDLE_W'(LOSS_LIMIT));
endmodule

// File: rtl/vlg_regs.sv
module vlg_regs
    import vlg_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LINE_W  = 12,
    parameter int FRM_W   = 8,
    parameter int PLANES  = 3,
    parameter int PLANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [REG_W-1:0]          rdata,
    input  logic                      stat_tx,
    input  logic                      stat_lost,
    input  logic [LINE_W-1:0]         meas_act,
    input  logic [LINE_W-1:0]         meas_tot,
    output logic                      ctrl_en,
    output logic                      ctrl_clean,
    output logic                      ctrl_apol,
    output logic [LINE_W-1:0]         ref_act,
    output logic [LINE_W-1:0]         ref_tot,
    output logic [LINE_W-1:0]         ref_lines,
    output logic [FRM_W-1:0]          ref_frames,
    output logic [PLANES*PLANE_W-1:0] pad_pix
);
    typedef struct packed {
        logic                            en;
        logic                            clean;
        logic                            apol;
        logic [LINE_W-1:0]               ra_act;
        logic [LINE_W-1:0]               ra_tot;
        logic [LINE_W-1:0]               rb_lines;
        logic [FRM_W-1:0]                rb_frm;
        logic [PLANES-1:0][PLANE_W-1:0]  pad;
    } regs_t;

    regs_t r_d, r_q;
    int    a;

    always_comb begin
        a   = int'(addr);
        r_d = r_q;
        if (wr_en) begin
            case (a)
                A_CTRL: begin
                    r_d.en    = wdata[CB_EN];
                    r_d.clean = wdata[CB_CLEAN];
                    r_d.apol  = wdata[CB_APOL];
                end
                A_REFA: begin
                    r_d.ra_tot = wdata[LINE_W-1:0];
                    r_d.ra_act = wdata[HI_FIELD +: LINE_W];
                end
                A_REFB: begin
                    r_d.rb_frm   = wdata[FRM_W-1:0];
                    r_d.rb_lines = wdata[HI_FIELD +: LINE_W];
                end
                default: begin
                    for (int p = 0; p < PLANES; p++)
                        if (a == A_PAD0 + p) r_d.pad[p] = wdata[PLANE_W-1:0];
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL: begin
                rdata[CB_EN]    = r_q.en;
                rdata[CB_CLEAN] = r_q.clean;
                rdata[CB_APOL]  = r_q.apol;
            end
            A_STAT: begin
                rdata[SB_TX]   = stat_tx;
                rdata[SB_LOST] = stat_lost;
            end
            A_REFA: begin
                rdata[LINE_W-1:0]          = r_q.ra_tot;
                rdata[HI_FIELD +: LINE_W]  = r_q.ra_act;
            end
            A_REFB: begin
                rdata[FRM_W-1:0]           = r_q.rb_frm;
                rdata[HI_FIELD +: LINE_W]  = r_q.rb_lines;
            end
            A_MACT: rdata[LINE_W-1:0] = meas_act;
            A_MTOT: rdata[LINE_W-1:0] = meas_tot;
            default: begin
                for (int p = 0; p < PLANES; p++)
                    if (a == A_PAD0 + p) rdata[PLANE_W-1:0] = r_q.pad[p];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_en    = r_q.en;
    assign ctrl_clean = r_q.clean;
    assign ctrl_apol  = r_q.apol;
    assign ref_act    = r_q.ra_act;
    assign ref_tot    = r_q.ra_tot;
    assign ref_lines  = r_q.rb_lines;
    assign ref_frames = r_q.rb_frm;
    assign pad_pix    = r_q.pad;
endmodule

// File: rtl/vlg_gate.sv
module vlg_gate #(
    parameter int LINE_W = 12,
    parameter int FRM_W  = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              ctrl_clean,
    input  logic [LINE_W-1:0] ref_act,
    input  logic [LINE_W-1:0] ref_tot,
    input  logic [LINE_W-1:0] ref_lines,
    input  logic [FRM_W-1:0]  ref_frames,
    input  logic              vs_edge,
    input  logic              frame_close,
    input  logic [LINE_W-1:0] close_act,
    input  logic [LINE_W-1:0] close_tot,
    input  logic              lost,
    input  logic              de,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] pad_pix,
    output logic              lock_now,
    output logic              tx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof
);
    typedef struct packed {
        logic [FRM_W-1:0]  cnt;
        logic              tx;
        logic              sof_pend;
        logic              ov;
        logic              osof;
        logic [DATA_W-1:0] od;
    } gate_t;

    gate_t g_d, g_q;
    logic              bypass, fmatch, pad_mode, pix;
    logic [FRM_W-1:0]  need;

    always_comb begin
        g_d    = g_q;
        bypass = (ref_act == '0) && (ref_tot == '0) &&
                 (ref_lines == '0) && (ref_frames == '0);
        need   = (ref_frames == '0) ? FRM_W'(1) : ref_frames;
        fmatch = (close_act == ref_act) && (close_tot == ref_tot) &&
                 (close_act == ref_lines);

        if (frame_close) begin
            if (!fmatch)
                g_d.cnt = '0;
            else if ((g_q.cnt != '1) && (g_q.cnt < need))
                g_d.cnt = g_q.cnt + FRM_W'(1);
        end
        lock_now = bypass || (g_d.cnt >= need);

        // decision only at frame boundary, with the control value held before this edge
        if (vs_edge) g_d.tx = ctrl_en && lock_now;

        pad_mode = lost && g_d.tx && ctrl_clean;
        pix      = g_d.tx && de;

        g_d.sof_pend = (vs_edge | g_q.sof_pend) & ~pix;
        if (pad_mode) begin
            g_d.ov   = 1'b1;
            g_d.od   = pad_pix;
            g_d.osof = 1'b0;
        end else begin
            g_d.ov   = pix;
            g_d.od   = data;
            g_d.osof = pix && (vs_edge || g_q.sof_pend);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign tx        = g_q.tx;
    assign out_valid = g_q.ov;
    assign out_data  = g_q.od;
    assign out_sof   = g_q.osof;
endmodule

// File: rtl/vid_lock_gate.sv
module vid_lock_gate
    import vlg_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int PLANES     = 3,
    parameter int LINE_W     = 12,
    parameter int FRM_W      = 8,
    parameter int POL_CNT_W  = 16,
    parameter int LOSS_LIMIT = 1024,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vid_data,
    input  logic              vid_de,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              input_lost
);
    localparam int PLANE_W = DATA_W / PLANES;
    localparam int N_SYNC  = 2;

    logic [N_SYNC-1:0] raw_sync, norm_sync;
    logic              ctrl_en, ctrl_clean, ctrl_apol;
    logic [LINE_W-1:0] ref_act, ref_tot, ref_lines;
    logic [FRM_W-1:0]  ref_frames;
    logic [DATA_W-1:0] pad_pix;
    logic              hs_edge_w, vs_edge_w, frame_close;
    logic [LINE_W-1:0] close_act, close_tot, meas_act, meas_tot;
    logic              lost_w, tx_w, lock_now_w;

    assign raw_sync = {vid_vs, vid_hs};

    for (genvar s = 0; s < N_SYNC; s++) begin : g_pol
        vlg_sync_pol #(.CNT_W(POL_CNT_W)) u_pol (
            .clk      (clk),
            .rst_n    (rst_n),
            .auto_en  (ctrl_apol),
            .raw_in   (raw_sync[s]),
            .sync_out (norm_sync[s])
        );
    end

    vlg_measure #(.LINE_W(LINE_W), .LOSS_LIMIT(LOSS_LIMIT)) u_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs          (norm_sync[0]),
        .vs          (norm_sync[1]),
        .de          (vid_de),
        .hs_edge     (hs_edge_w),
        .vs_edge     (vs_edge_w),
        .frame_close (frame_close),
        .close_act   (close_act),
        .close_tot   (close_tot),
        .meas_act    (meas_act),
        .meas_tot    (meas_tot),
        .lost        (lost_w)
    );

    vlg_regs #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .FRM_W(FRM_W),
        .PLANES(PLANES), .PLANE_W(PLANE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .stat_tx    (tx_w),
        .stat_lost  (lost_w),
        .meas_act   (meas_act),
        .meas_tot   (meas_tot),
        .ctrl_en    (ctrl_en),
        .ctrl_clean (ctrl_clean),
        .ctrl_apol  (ctrl_apol),
        .ref_act    (ref_act),
        .ref_tot    (ref_tot),
        .ref_lines  (ref_lines),
        .ref_frames (ref_frames),
        .pad_pix    (pad_pix)
    );

    vlg_gate #(.LINE_W(LINE_W), .FRM_W(FRM_W), .DATA_W(DATA_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_en     (ctrl_en),
        .ctrl_clean  (ctrl_clean),
        .ref_act     (ref_act),
        .ref_tot     (ref_tot),
        .ref_lines   (ref_lines),
        .ref_frames  (ref_frames),
        .vs_edge     (vs_edge_w),
        .frame_close (frame_close),
        .close_act   (close_act),
        .close_tot   (close_tot),
        .lost        (lost_w),
        .de          (vid_de),
        .data        (vid_data),
        .pad_pix     (pad_pix),
        .lock_now    (lock_now_w),
        .tx          (tx_w),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_sof     (out_sof)
    );

    assign input_lost = lost_w;
endmodule

// File: rtl/vid_lock_gate_chk.sv
module vid_lock_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic out_sof,
    input logic tx,
    input logic vs_edge,
    input logic hs_edge,
    input logic lost,
    input logic ctrl_en,
    input logic ctrl_clean,
    input logic lock_now
);
    // R3: no pixel leaves unless the gate is open
    a_r3_valid_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> tx);

    // R3: frame start marker only on a valid pixel
    a_r3_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R7: gate state moves only after a vertical sync leading edge
    a_r7_tx_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (tx != $past(tx)) |-> $past(vs_edge));

    // R4 / R5: opening requires enable and lock in the deciding cycle
    a_r5_open_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx) |-> $past(ctrl_en && lock_now));

    // R11: a horizontal sync edge clears the loss flag
    a_r11_edge_clears_loss: assert property (@(posedge clk) disable iff (!rst_n)
        hs_edge |=> !lost);

    // R12: padding is emitted on every cycle while lost with cleaner on
    a_r12_pad_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && tx && ctrl_clean && !vs_edge) |=> out_valid);
endmodule

bind vid_lock_gate vid_lock_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .tx         (tx_w),
    .vs_edge    (vs_edge_w),
    .hs_edge    (hs_edge_w),
    .lost       (lost_w),
    .ctrl_en    (ctrl_en),
    .ctrl_clean (ctrl_clean),
    .lock_now   (lock_now_w)
);

// File: tb/test_vid_lock_gate.sv
module test_vid_lock_gate;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 32;
    localparam int HS_W       = 4;
    localparam int DE_START   = 8;
    localparam int AW         = 16;
    localparam int TOT        = 12;
    localparam int ACT        = 6;
    localparam int LOSS       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] vid_data = '0;
    logic        vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        out_valid, out_sof, input_lost;
    logic [23:0] out_data;

    vid_lock_gate i_vid_lock_gate (
        .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .vid_de(vid_de),
        .vid_hs(vid_hs), .vid_vs(vid_vs), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_sof(out_sof), .input_lost(input_lost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_vec = 0, n_bad = 0, pad_seen = 0;
    bit          discard = 1'b0, pad_expect = 1'b0, done = 1'b0;
    logic [23:0] pad_val = '0;
    logic [23:0] seed = 24'h000100;
    logic [24:0] exp_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (discard) begin
            end else if (pad_expect) begin
                check("R12 pad pixel", {8'h0, out_data}, {8'h0, pad_val});
                pad_seen++;
            end else if (exp_q.size() == 0) begin
                check("R3 unexpected pixel", {7'h0, out_sof, out_data}, 32'hFFFF_FFFF);
            end else begin
                logic [24:0] e;
                e = exp_q.pop_front();
                check("R3 pixel sof/data", {7'h0, out_sof, out_data}, {7'h0, e});
            end
        end
    end

    task automatic wr_reg(input int a, input logic [31:0] v);
        reg_addr  = 4'(a);
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        reg_addr = 4'(a);
        #1;
        v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic drive_frame(input int tot, input bit low, input bit expect_tx);
        bit first;
        first = 1'b1;
        for (int ln = 0; ln < tot; ln++) begin
            for (int c = 0; c < LINE_LEN; c++) begin
                logic de;
                de       = (ln >= 2) && (ln < 2 + ACT) && (c >= DE_START) && (c < DE_START + AW);
                vid_hs   = (c < HS_W) ^ low;
                vid_vs   = (ln < 2) ^ low;
                vid_de   = de;
                vid_data = seed;
                if (de) begin
                    if (expect_tx) exp_q.push_back({first, seed});
                    first = 1'b0;
                    seed  = seed + 24'h010203;
                end
                @(negedge clk);
            end
        end
        vid_hs = low;
        vid_vs = low;
        vid_de = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_sof", {31'h0, out_sof}, 32'h0);
        rd_reg(0, v); check("R1 ctrl word", v, 32'h0);
        rd_reg(1, v); check("R1 status word", v, 32'h0);

        // R2 measuring while disabled, nothing output
        for (int f = 0; f < 3; f++) drive_frame(TOT, 1'b0, 1'b0);
        rd_reg(7, v); check("R2 measured active", v, ACT);
        rd_reg(8, v); check("R2 measured total", v, TOT);
        check("R2 nothing sent while disabled", exp_q.size(), 0);

        // R4 bypass, enable between frames
        wr_reg(0, 32'h1);
        drive_frame(TOT, 1'b0, 1'b1);
        rd_reg(1, v); check("R9 status transmitting", v, 32'h10);

        // R5 references with two frames required
        wr_reg(2, (ACT << 16) | TOT);
        wr_reg(3, (ACT << 16) | 2);
        drive_frame(TOT, 1'b0, 1'b0);
        rd_reg(1, v); check("R9 R5 status while counting", v, 32'h0);
        drive_frame(TOT, 1'b0, 1'b1);
        rd_reg(1, v); check("R5 status after lock", v, 32'h10);

        // R6 one bad frame drops lock
        drive_frame(TOT + 1, 1'b0, 1'b1);
        drive_frame(TOT, 1'b0, 1'b0);
        drive_frame(TOT, 1'b0, 1'b0);
        drive_frame(TOT, 1'b0, 1'b1);
        check("R6 queue drained", exp_q.size(), 0);

        // R7 clearing enable mid-frame
        fork
            drive_frame(TOT, 1'b0, 1'b1);
            begin idle(150); wr_reg(0, 32'h0); end
        join
        drive_frame(TOT, 1'b0, 1'b0);
        rd_reg(1, v); check("R7 R9 stopped at boundary", v, 32'h0);
        // R7 setting enable mid-frame
        fork
            drive_frame(TOT, 1'b0, 1'b0);
            begin idle(150); wr_reg(0, 32'h1); end
        join
        drive_frame(TOT, 1'b0, 1'b1);

        // R8 control write on the boundary cycle
        fork
            drive_frame(TOT, 1'b0, 1'b1);
            wr_reg(0, 32'h0);
        join
        drive_frame(TOT, 1'b0, 1'b0);
        fork
            drive_frame(TOT, 1'b0, 1'b0);
            wr_reg(0, 32'h1);
        join
        drive_frame(TOT, 1'b0, 1'b1);
        check("R8 queue drained", exp_q.size(), 0);

        // R11 / R12 loss and padding
        wr_reg(4, 32'h11);
        wr_reg(5, 32'h22);
        wr_reg(6, 32'h33);
        rd_reg(5, v); check("R12 pad word readback", v, 32'h22);
        pad_val = 24'h332211;
        wr_reg(0, 32'h9);
        pad_expect = 1'b1;
        idle(LOSS + 40);
        check("R11 input_lost", {31'h0, input_lost}, 32'h1);
        rd_reg(1, v); check("R11 status lost", v, 32'h12);
        check("R12 padding emitted", {31'h0, pad_seen > 10}, 32'h1);
        wr_reg(0, 32'h1);
        @(negedge clk);
        pad_expect = 1'b0;
        idle(50);
        check("R12 no pad with cleaner off", {31'h0, out_valid}, 32'h0);

        // R10 active-low syncs with auto polarity
        discard = 1'b1;
        rst_n   = 1'b0;
        idle(3);
        rst_n  = 1'b1;
        vid_hs = 1'b1;
        vid_vs = 1'b1;
        wr_reg(0, 32'h11);
        for (int f = 0; f < 4; f++) drive_frame(TOT, 1'b1, 1'b0);
        idle(2);
        discard = 1'b0;
        rd_reg(7, v); check("R10 active-low active lines", v, ACT);
        rd_reg(8, v); check("R10 active-low total lines", v, TOT);
        drive_frame(TOT, 1'b1, 1'b1);
        idle(4);
        check("R10 R3 all pixels seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule